// File: doc/BRIEF.md
# Stored-Program Accumulator Machine Core

This core executes programs held in a single writable memory of 2^W words, each W bits wide. Code, data and the three machine registers all share that memory: word 0 holds the program counter, word 1 the instruction register and word 2 the accumulator. Because the registers are ordinary memory words, a program can rewrite its own code or redirect itself by storing into word 0.

The core runs a fetch, decode and execute sequence and performs one memory write per clock. An instruction that carries an operand takes that operand from the word after its opcode. A build-time parameter picks the arithmetic flavour. In the first flavour, opcodes 2 and 3 increment and decrement the accumulator and take no operand. In the second, they add or subtract an inline constant. In the third, they add or subtract the word stored at an operand address.

Software loads the image through the preload port while the core is idle and then pulses start. When the program ends, halted goes high, and the same port reads back results.

Top module: `spm_core`

## Requirements
- R1: After reset every memory word reads 0, halted is low and the core is idle. Because 0 is the HALT code, unused memory therefore holds HALT.
- R2: A preload write changes the addressed word only while the core is idle, and a preload write made during a run has no effect. load_rdata_o always returns the word at load_addr_i.
- R3: Opcode encoding is 0 HALT, 1 LOAD k, 2 ADD/INC, 3 SUB/DEC, 4 CPY a (ACC←mem[a]), 5 STO a (mem[a]←ACC), 6 JMP a, 7 JZ a. The core copies the opcode word at PC into word 1 and moves PC past the opcode. If the instruction has an operand, the core copies the operand into word 1 and, after execution, moves PC past the operand as well. LOAD k sets ACC to k.
- R4: In the increment/decrement flavour, opcodes 2 and 3 have no operand. ACC wraps from 2^W−1 to 0 on increment and from 0 to 2^W−1 on decrement.
- R5: In the immediate flavour, ADD k and SUB k add or subtract the constant k from ACC, modulo 2^W.
- R6: In the memory-operand flavour, ADD a and SUB a add or subtract mem[a] from ACC, modulo 2^W.
- R7: CPY a loads ACC from mem[a]. STO a writes ACC into mem[a].
- R8: JMP a sets PC to a with no further increment. JZ a does the same when ACC is 0; otherwise execution continues after its operand.
- R9: Decoding HALT, or any value of 8 or more, raises halted and leaves PC at that instruction. halted stays high until the next start.
- R10: A STO into program memory changes the instruction that is executed later.
- R11: Advancing PC from 2^W−1 wraps it to 0.
- R12: Counting from the clock edge that samples start, halted rises 1 + Σ cycles + 2 edges later. Each instruction costs 3 cycles without an operand, 5 with an operand, and 4 for a taken jump. The final 2 cycles are the HALT fetch and decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin execution at mem[0] when idle |
| halted_o | output | 1 | Program reached HALT or an undefined opcode |
| load_we_i | input | 1 | Preload write enable, accepted only when idle |
| load_addr_i | input | W | Preload and readback address |
| load_data_i | input | W | Preload write data |
| load_rdata_o | output | W | Word at load_addr_i |

## Verification
Two situations are hard to reach from the ports: a program counter that wraps past the top of memory, and a program that rewrites its own code. For the wrap, the bench presets word 0 to the last address and places an operand-free increment there. PC then wraps onto word 0, and word 0 decodes as HALT. For self-modification, the program stores a jump opcode over a HALT that lies ahead of it. The bench also drives a preload write in the middle of a run and reads the target word back afterwards. It counts edges from start to halted to pin down the per-instruction cycle cost.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [2:0] {
    OP_HALT = 3'd0, OP_LOAD = 3'd1, OP_ADD = 3'd2, OP_SUB = 3'd3,
    OP_CPY  = 3'd4, OP_STO  = 3'd5, OP_JMP = 3'd6, OP_JZ  = 3'd7
  } op_e;

  typedef enum logic [1:0] {PH_IDLE, PH_FETCH, PH_DECODE, PH_EXEC} phase_e;

  localparam int ISA_INCDEC = 0;
  localparam int ISA_IMM    = 1;
  localparam int ISA_MEM    = 2;

  localparam int PC_ADDR  = 0;
  localparam int IR_ADDR  = 1;
  localparam int ACC_ADDR = 2;
endpackage

// File: rtl/spm_mem.sv
module spm_mem #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         idle_i,
  input  logic         core_we_i,
  input  logic [W-1:0] core_addr_i,
  input  logic [W-1:0] core_data_i,
  input  logic         load_we_i,
  input  logic [W-1:0] load_addr_i,
  input  logic [W-1:0] load_data_i,
  output logic [W-1:0] load_rdata_o,
  output logic [W-1:0] pc_o,
  output logic [W-1:0] ir_o,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] at_pc_o,
  output logic [W-1:0] at_ir_o
);
  localparam int DEPTH = 1 << W;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (core_we_i) begin
      mem_q[core_addr_i] <= core_data_i;
    end else if (load_we_i && idle_i) begin
      mem_q[load_addr_i] <= load_data_i;
    end
  end

  assign pc_o         = mem_q[spm_pkg::PC_ADDR];
  assign ir_o         = mem_q[spm_pkg::IR_ADDR];
  assign acc_o        = mem_q[spm_pkg::ACC_ADDR];
  assign at_pc_o      = mem_q[pc_o];
  assign at_ir_o      = mem_q[ir_o];
  assign load_rdata_o = mem_q[load_addr_i];

  AST_CORE_WR_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_we_i |-> !idle_i); // R2
endmodule

// File: rtl/spm_alu.sv
module spm_alu
  import spm_pkg::*;
#(
  parameter int W   = 8,
  parameter int ISA = ISA_IMM
) (
  input  op_e          op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] ir_i,
  input  logic [W-1:0] at_ir_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] opnd;

  generate
    if (ISA == ISA_INCDEC) begin : g_incdec
      assign opnd = W'(1);
    end else if (ISA == ISA_IMM) begin : g_imm
      assign opnd = ir_i;
    end else begin : g_mem
      assign opnd = at_ir_i;
    end
  endgenerate

  always_comb begin
    unique case (op_i)
      OP_LOAD: res_o = ir_i;
      OP_ADD:  res_o = acc_i + opnd;
      OP_SUB:  res_o = acc_i - opnd;
      OP_CPY:  res_o = at_ir_i;
      default: res_o = acc_i;
    endcase
  end
endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import spm_pkg::*;
#(
  parameter int W   = 8,
  parameter int ISA = ISA_IMM
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] ir_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] at_pc_i,
  input  logic [W-1:0] alu_res_i,
  output op_e          alu_op_o,
  output logic         core_we_o,
  output logic [W-1:0] core_addr_o,
  output logic [W-1:0] core_data_o,
  output logic         idle_o,
  output logic         halted_o
);
  localparam logic [W-1:0] A_PC  = W'(PC_ADDR);
  localparam logic [W-1:0] A_IR  = W'(IR_ADDR);
  localparam logic [W-1:0] A_ACC = W'(ACC_ADDR);

  phase_e     phase_q, phase_d;
  logic [1:0] step_q, step_d;   // inner stage: 0 operand, 1 act, 2 advance
  op_e        op_q, op_d;
  logic       halted_q, halted_d;

  logic ir_valid;
  op_e  ir_op;
  assign ir_valid = (ir_i < W'(8));
  assign ir_op    = op_e'(ir_i[2:0]);

  function automatic logic has_opnd(op_e op);
    return !((op == OP_ADD || op == OP_SUB) && ISA == ISA_INCDEC);
  endfunction

  always_comb begin
    phase_d     = phase_q;
    step_d      = step_q;
    op_d        = op_q;
    halted_d    = halted_q;
    core_we_o   = 1'b0;
    core_addr_o = '0;
    core_data_o = '0;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d  = PH_FETCH;
        halted_d = 1'b0;
      end
      PH_FETCH: begin
        core_we_o = 1'b1; core_addr_o = A_IR; core_data_o = at_pc_i;
        phase_d   = PH_DECODE;
      end
      PH_DECODE: begin
        if (!ir_valid || ir_op == OP_HALT) begin
          halted_d = 1'b1;
          phase_d  = PH_IDLE;
        end else begin
          core_we_o = 1'b1; core_addr_o = A_PC; core_data_o = pc_i + W'(1);
          op_d    = ir_op;
          phase_d = PH_EXEC;
          step_d  = has_opnd(ir_op) ? 2'd0 : 2'd1;
        end
      end
      PH_EXEC: begin
        unique case (step_q)
          2'd0: begin
            core_we_o = 1'b1; core_addr_o = A_IR; core_data_o = at_pc_i;
            step_d    = 2'd1;
          end
          2'd1: begin
            unique case (op_q)
              OP_STO: begin
                core_we_o = 1'b1; core_addr_o = ir_i; core_data_o = acc_i;
                step_d    = 2'd2;
              end
              OP_JMP: begin
                core_we_o = 1'b1; core_addr_o = A_PC; core_data_o = ir_i;
                phase_d   = PH_FETCH;
              end
              OP_JZ: begin
                if (acc_i == '0) begin
                  core_we_o = 1'b1; core_addr_o = A_PC; core_data_o = ir_i;
                  phase_d   = PH_FETCH;
                end else begin
                  step_d = 2'd2;
                end
              end
              default: begin
                core_we_o = 1'b1; core_addr_o = A_ACC; core_data_o = alu_res_i;
                if (has_opnd(op_q)) step_d = 2'd2;
                else                phase_d = PH_FETCH;
              end
            endcase
          end
          default: begin
            core_we_o = 1'b1; core_addr_o = A_PC; core_data_o = pc_i + W'(1);
            phase_d   = PH_FETCH;
          end
        endcase
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      step_q   <= '0;
      op_q     <= OP_HALT;
      halted_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      step_q   <= step_d;
      op_q     <= op_d;
      halted_q <= halted_d;
    end
  end

  assign alu_op_o = op_q;
  assign idle_o   = (phase_q == PH_IDLE);
  assign halted_o = halted_q;

  AST_FETCH_IR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FETCH) |=> (ir_i == $past(at_pc_i))); // R3
  AST_DECODE_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DECODE && ir_valid && ir_op != OP_HALT)
      |=> (pc_i == $past(pc_i) + W'(1))); // R11
  AST_JUMP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC && step_q == 2'd1 && op_q == OP_JMP)
      |=> (pc_i == $past(ir_i))); // R8
  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_q && !start_i) |=> halted_q); // R9
  AST_HALT_PC_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DECODE && (!ir_valid || ir_op == OP_HALT))
      |=> (pc_i == $past(pc_i))); // R9
endmodule

// File: rtl/spm_core.sv
module spm_core
  import spm_pkg::*;
#(
  parameter int W   = 8,
  parameter int ISA = ISA_IMM
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  output logic         halted_o,
  input  logic         load_we_i,
  input  logic [W-1:0] load_addr_i,
  input  logic [W-1:0] load_data_i,
  output logic [W-1:0] load_rdata_o
);
  logic         idle, core_we;
  logic [W-1:0] core_addr, core_data;
  logic [W-1:0] pc, ir, acc, at_pc, at_ir, alu_res;
  op_e          alu_op;

  spm_mem #(.W(W)) u_mem (
    .clk_i, .rst_ni,
    .idle_i      (idle),
    .core_we_i   (core_we),
    .core_addr_i (core_addr),
    .core_data_i (core_data),
    .load_we_i, .load_addr_i, .load_data_i, .load_rdata_o,
    .pc_o        (pc),
    .ir_o        (ir),
    .acc_o       (acc),
    .at_pc_o     (at_pc),
    .at_ir_o     (at_ir)
  );

  spm_alu #(.W(W), .ISA(ISA)) u_alu (
    .op_i    (alu_op),
    .acc_i   (acc),
    .ir_i    (ir),
    .at_ir_i (at_ir),
    .res_o   (alu_res)
  );

  spm_ctrl #(.W(W), .ISA(ISA)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .pc_i        (pc),
    .ir_i        (ir),
    .acc_i       (acc),
    .at_pc_i     (at_pc),
    .alu_res_i   (alu_res),
    .alu_op_o    (alu_op),
    .core_we_o   (core_we),
    .core_addr_o (core_addr),
    .core_data_o (core_data),
    .idle_o      (idle),
    .halted_o    (halted_o)
  );
endmodule

// File: tb/spm_core_tb.sv
module spm_core_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] we_s = '0;
  logic [2:0] start_s = '0;
  logic [2:0] halted_w;
  logic [7:0] addr_s = '0;
  logic [7:0] data_s = '0;
  logic [7:0] rdata_w [3];
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spm_core #(.W(8), .ISA(0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_s[0]), .halted_o(halted_w[0]),
    .load_we_i(we_s[0]), .load_addr_i(addr_s), .load_data_i(data_s),
    .load_rdata_o(rdata_w[0]));
  spm_core #(.W(8), .ISA(1)) u_dut_imm (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_s[1]), .halted_o(halted_w[1]),
    .load_we_i(we_s[1]), .load_addr_i(addr_s), .load_data_i(data_s),
    .load_rdata_o(rdata_w[1]));
  spm_core #(.W(8), .ISA(2)) u_dut_mem (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_s[2]), .halted_o(halted_w[2]),
    .load_we_i(we_s[2]), .load_addr_i(addr_s), .load_data_i(data_s),
    .load_rdata_o(rdata_w[2]));

  task automatic check(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(input int k, input int a, input int d);
    @(negedge clk);
    addr_s = a[7:0]; data_s = d[7:0]; we_s[k] = 1'b1;
    @(negedge clk);
    we_s[k] = 1'b0;
  endtask

  task automatic peek(input int k, input int a, output int v);
    @(negedge clk);
    addr_s = a[7:0];
    #1 v = int'(rdata_w[k]);
  endtask

  task automatic run(input int k, output int cyc);
    @(negedge clk);
    start_s[k] = 1'b1;
    @(negedge clk);
    start_s[k] = 1'b0;
    cyc = 1;
    while (!halted_w[k] && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    check("R1 halted after reset", int'(halted_w), 0);
    peek(0, 0, v);   check("R1 word0 zero", v, 0);
    peek(1, 2, v);   check("R1 word2 zero", v, 0);
    peek(2, 200, v); check("R1 word200 zero", v, 0);
    run(1, v);
    check("R1 empty memory halts", int'(halted_w[1]), 1);
  endtask

  task automatic t_incdec();
    int v, c;
    do_reset();
    put(0, 0, 3);
    peek(0, 0, v); check("R2 preload readback", v, 3);
    put(0, 3, 1); put(0, 4, 254); put(0, 5, 2); put(0, 6, 2);
    run(0, c);
    peek(0, 2, v); check("R4 increment wraps to 0", v, 0);
    peek(0, 0, v); check("R9 PC left at HALT", v, 7);
    do_reset();
    put(0, 0, 3); put(0, 3, 1); put(0, 4, 0); put(0, 5, 3);
    run(0, c);
    peek(0, 2, v); check("R4 decrement wraps to 255", v, 255);
  endtask

  task automatic t_imm();
    int v, c;
    do_reset();
    put(1, 0, 3);
    put(1, 3, 1); put(1, 4, 250);
    put(1, 5, 2); put(1, 6, 10);
    put(1, 7, 3); put(1, 8, 5);
    put(1, 9, 5); put(1, 10, 100);
    run(1, c);
    peek(1, 2, v);   check("R5 imm add/sub wrap", v, 255);
    peek(1, 100, v); check("R7 STO result", v, 255);
    peek(1, 0, v);   check("R3 PC past operands", v, 11);
    peek(1, 1, v);   check("R3 IR holds last fetched word", v, 0);
  endtask

  task automatic t_memop();
    int v, c;
    do_reset();
    put(2, 50, 7); put(2, 51, 9);
    put(2, 0, 3);
    put(2, 3, 1); put(2, 4, 1);
    put(2, 5, 2); put(2, 6, 50);
    put(2, 7, 3); put(2, 8, 51);
    put(2, 9, 5); put(2, 10, 60);
    put(2, 11, 4); put(2, 12, 51);
    run(2, c);
    peek(2, 60, v); check("R6 mem add/sub wrap", v, 255);
    peek(2, 2, v);  check("R7 CPY loads mem", v, 9);
  endtask

  task automatic t_jumps();
    int v, c;
    do_reset();
    put(1, 0, 3);
    put(1, 3, 1); put(1, 4, 0);
    put(1, 5, 7); put(1, 6, 20);
    put(1, 7, 1); put(1, 8, 99);
    put(1, 20, 1); put(1, 21, 5);
    put(1, 22, 7); put(1, 23, 40);
    put(1, 24, 6); put(1, 25, 30);
    put(1, 40, 1); put(1, 41, 77);
    run(1, c);
    peek(1, 2, v); check("R8 JZ not taken when ACC nonzero", v, 5);
    peek(1, 0, v); check("R8 JMP target without increment", v, 30);
  endtask

  task automatic t_undef();
    int v, c;
    do_reset();
    put(1, 0, 3); put(1, 3, 200);
    run(1, c);
    check("R9 undefined opcode halts", int'(halted_w[1]), 1);
    peek(1, 0, v); check("R9 PC stays on undefined", v, 3);
    repeat (10) @(negedge clk);
    check("R9 halted sticky", int'(halted_w[1]), 1);
  endtask

  task automatic t_selfmod();
    int v, c;
    do_reset();
    put(1, 0, 3);
    put(1, 3, 1); put(1, 4, 6);
    put(1, 5, 5); put(1, 6, 7);
    put(1, 8, 20);
    put(1, 20, 1); put(1, 21, 42);
    run(1, c);
    peek(1, 2, v); check("R10 patched jump executed", v, 42);
    peek(1, 0, v); check("R10 halt after patched path", v, 22);
  endtask

  task automatic t_pcwrap();
    int v, c;
    do_reset();
    put(0, 0, 255); put(0, 255, 2);
    run(0, c);
    peek(0, 2, v); check("R11 INC at top executed", v, 1);
    peek(0, 0, v); check("R11 PC wrapped to 0", v, 0);
  endtask

  task automatic t_busy_preload();
    int v, c;
    do_reset();
    put(0, 0, 3);
    for (int a = 3; a <= 20; a++) put(0, a, 2);
    @(negedge clk);
    start_s[0] = 1'b1;
    @(negedge clk);
    start_s[0] = 1'b0;
    repeat (4) @(negedge clk);
    addr_s = 8'd100; data_s = 8'd55; we_s[0] = 1'b1;
    @(negedge clk);
    we_s[0] = 1'b0;
    c = 0;
    while (!halted_w[0] && c < 5000) begin
      @(negedge clk);
      c++;
    end
    peek(0, 100, v); check("R2 preload ignored while running", v, 0);
    peek(0, 2, v);   check("R4 INC chain", v, 18);
  endtask

  task automatic t_timing();
    int c;
    do_reset();
    put(1, 0, 3); put(1, 3, 1); put(1, 4, 9);
    run(1, c);
    check("R12 LOAD+HALT edges", c, 8);
    do_reset();
    put(0, 0, 3); put(0, 3, 2);
    run(0, c);
    check("R12 INC+HALT edges", c, 6);
    do_reset();
    put(1, 0, 3); put(1, 3, 6); put(1, 4, 10);
    run(1, c);
    check("R12 JMP+HALT edges", c, 7);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_incdec();
    t_imm();
    t_memop();
    t_jumps();
    t_undef();
    t_selfmod();
    t_pcwrap();
    t_busy_preload();
    t_timing();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule